// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It drives a trial code to an external DAC, reads back a single comparator bit, and narrows the trial code one bit at a time, starting from the most significant bit, until the code matches the analog input. The analog parts (the DAC, the comparator and the clock source) sit outside the block.

A conversion is requested with a start pulse, and the sequence runs once that pulse ends. The finished code stays in the result register until the next start. The code is read through a parallel word with separate drive enables for its upper and lower parts. A completion flag has its own enable. While the conversion runs, an NRZ serial stream with a mid-bit strobe comes out as well. A mode input cuts the conversion short to 8 decided bits. Tri-state behaviour is modelled as a value plus a drive-enable, so a wrapper can turn it into high impedance where that is needed.

Time is counted in bit steps. One step lasts `SYNC_STAGES + SETTLE + 1` clock cycles, which is 4 cycles with the default parameters. This covers the trial-code change, the comparator synchroniser latency and one settle cycle.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While `start_i` is high, the trial code on `trial_o` is one in the top bit and zero in all others, and `done_o` is 0.
- R2: The conversion begins on the clock edge that first samples `start_i` low. A start that arrives during a conversion abandons it and restarts from the top bit.
- R3: The top-bit decision happens 2 steps after the edge that begins the conversion. Each lower bit is decided exactly one step after the bit above it, and the next lower bit turns on as the new trial at that same edge.
- R4: At each decision, the trial bit is cleared when the synchronised `cmp_i` is 1 (DAC above input) and kept otherwise. In full mode (`full_mode_i` = 1) the final code equals the largest code that does not exceed the input.
- R5: In short mode (`full_mode_i` = 0 at the start of the conversion), bit 2 is the last decided bit. Bit 1 goes to 1 at that decision and stays there, and bit 0 stays 0.
- R6: `done_o` is 1 after reset and when a conversion is complete, and 0 while one is running. It rises one step after the final decision: 48 cycles after the begin edge in full mode and 40 in short mode.
- R7: `data_oe_o` bits 9 and 8 follow `hi_en_i`, bits 7 to 0 follow `lo_en_i`, and `done_oe_o` follows `stat_en_i`.
- R8: After completion, `data_o` holds the result unchanged until the next start, whatever `cmp_i` does.
- R9: `ser_o` carries the decided bits, top bit first, one per step, and stays stable around each rising edge of `sync_o`. `sync_o` is low in the first half of each step and high in the second half. It gives 10 rising edges in full mode and 8 in short mode. `ser_oe_o` is 1 only from the begin edge until completion.
- R10: `clk_run_o` is 1 from the edge that samples the start until completion, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request; the sequence runs after it falls |
| full_mode_i | input | 1 | 1 = 10-bit conversion, 0 = 8-bit short conversion |
| cmp_i | input | 1 | Comparator result, 1 when DAC output exceeds the input |
| hi_en_i | input | 1 | Drive enable for the two upper result bits |
| lo_en_i | input | 1 | Drive enable for the eight lower result bits |
| stat_en_i | input | 1 | Drive enable for the completion flag |
| trial_o | output | 10 | Trial code to the DAC |
| data_o | output | 10 | Result register value |
| data_oe_o | output | 10 | Per-bit drive enable of `data_o` |
| done_o | output | 1 | Completion flag (1 = complete) |
| done_oe_o | output | 1 | Drive enable of `done_o` |
| ser_o | output | 1 | NRZ serial result, top bit first |
| sync_o | output | 1 | Mid-bit strobe for `ser_o` |
| ser_oe_o | output | 1 | Drive enable of `ser_o` and `sync_o` |
| clk_run_o | output | 1 | High while a conversion is in progress |

## Verification
The assertions assume three things about the inputs. `cmp_i` depends only on the current trial code and settles within one cycle of a code change. `start_i` is synchronous to `clk`. `full_mode_i` does not change between a start and the completion that follows it. The bench's comparator model is a combinational comparison of `trial_o` against a chosen input code, so the first condition always holds. The bench changes the mode only while it drives the start pulse, and it changes the input code only outside a running conversion, except in the deliberate abort case.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_BITS,
        ST_TAIL
    } sar_state_e;

    typedef struct packed {
        logic load;
        logic decide;
        logic run;
        logic window;
        logic strobe;
    } sar_ctl_t;

endpackage

// File: rtl/sar_cmp_sync.sv
module sar_cmp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int N       = 10,
    parameter int SHORT_N = 8,
    parameter int STEP    = 4,
    localparam int IW     = $clog2(N),
    localparam int PW     = (STEP > 1) ? $clog2(STEP) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          full_mode_i,
    output sar_ctl_t      ctl_o,
    output logic [IW-1:0] idx_o
);
    localparam logic [PW-1:0] PH_END = PW'(STEP - 1);
    localparam logic [PW-1:0] PH_MID = PW'(STEP / 2);
    localparam logic [IW-1:0] TOP    = IW'(N - 1);
    localparam logic [IW-1:0] LAST_S = IW'(N - SHORT_N);

    sar_state_e    st;
    logic [PW-1:0] ph;
    logic [IW-1:0] idx;
    logic          mode_full;
    logic          shown;
    logic [IW-1:0] last_idx;
    logic          step_end;

    assign last_idx = mode_full ? '0 : LAST_S;
    assign step_end = (ph == PH_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            ph        <= '0;
            idx       <= TOP;
            mode_full <= 1'b1;
            shown     <= 1'b0;
        end else if (start_i) begin
            st    <= ST_LOAD;
            ph    <= '0;
            idx   <= TOP;
            shown <= 1'b0;
        end else begin
            case (st)
                ST_LOAD: begin
                    st        <= ST_LEAD;
                    ph        <= '0;
                    mode_full <= full_mode_i;
                end
                ST_LEAD: begin
                    ph <= step_end ? '0 : ph + 1'b1;
                    if (step_end) st <= ST_BITS;
                end
                ST_BITS: begin
                    ph <= step_end ? '0 : ph + 1'b1;
                    if (step_end) begin
                        shown <= 1'b1;
                        if (idx == last_idx) st <= ST_TAIL;
                        else                 idx <= idx - 1'b1;
                    end
                end
                ST_TAIL: begin
                    ph <= step_end ? '0 : ph + 1'b1;
                    if (step_end) begin
                        st    <= ST_IDLE;
                        shown <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ctl_o.load   = start_i;
        ctl_o.decide = (st == ST_BITS) && step_end && !start_i;
        ctl_o.run    = (st != ST_IDLE);
        ctl_o.window = (st inside {ST_LEAD, ST_BITS, ST_TAIL});
        ctl_o.strobe = shown && (st inside {ST_BITS, ST_TAIL}) && (ph >= PH_MID);
    end

    assign idx_o = idx;
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath #(
    parameter int N   = 10,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          decide_i,
    input  logic [IW-1:0] idx_i,
    input  logic          cmp_i,
    output logic [N-1:0]  code_o,
    output logic          ser_o
);
    localparam logic [N-1:0] TOP_ONLY = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] code;
    logic         ser_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            code    <= '0;
            ser_bit <= 1'b0;
        end else if (load_i) begin
            code    <= TOP_ONLY;
            ser_bit <= 1'b0;
        end else if (decide_i) begin
            code[idx_i] <= ~cmp_i;
            if (idx_i != '0) code[idx_i - 1'b1] <= 1'b1;
            ser_bit <= ~cmp_i;
        end
    end

    assign code_o = code;
    assign ser_o  = ser_bit;
endmodule

// File: rtl/sar_drive.sv
module sar_drive #(
    parameter int N    = 10,
    parameter int LO_W = 8
) (
    input  logic         hi_en_i,
    input  logic         lo_en_i,
    input  logic         stat_en_i,
    input  logic         window_i,
    output logic [N-1:0] data_oe_o,
    output logic         done_oe_o,
    output logic         ser_oe_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_oe
            if (i >= LO_W) begin : g_hi
                assign data_oe_o[i] = hi_en_i;
            end else begin : g_lo
                assign data_oe_o[i] = lo_en_i;
            end
        end
    endgenerate

    assign done_oe_o = stat_en_i;
    assign ser_oe_o  = window_i;
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int N           = 10,
    parameter int SHORT_N     = 8,
    parameter int LO_W        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         full_mode_i,
    input  logic         cmp_i,
    input  logic         hi_en_i,
    input  logic         lo_en_i,
    input  logic         stat_en_i,
    output logic [N-1:0] trial_o,
    output logic [N-1:0] data_o,
    output logic [N-1:0] data_oe_o,
    output logic         done_o,
    output logic         done_oe_o,
    output logic         ser_o,
    output logic         sync_o,
    output logic         ser_oe_o,
    output logic         clk_run_o
);
    localparam int STEP = SYNC_STAGES + SETTLE + 1;
    localparam int IW   = $clog2(N);

    sar_ctl_t      ctl;
    logic [IW-1:0] idx;
    logic          cmp_s;
    logic [N-1:0]  code;

    sar_cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cmp_i),
        .q_o (cmp_s)
    );

    sar_sequencer #(.N(N), .SHORT_N(SHORT_N), .STEP(STEP)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .full_mode_i (full_mode_i),
        .ctl_o       (ctl),
        .idx_o       (idx)
    );

    sar_datapath #(.N(N)) u_dp (
        .clk      (clk),
        .rst      (rst),
        .load_i   (ctl.load),
        .decide_i (ctl.decide),
        .idx_i    (idx),
        .cmp_i    (cmp_s),
        .code_o   (code),
        .ser_o    (ser_o)
    );

    sar_drive #(.N(N), .LO_W(LO_W)) u_drv (
        .hi_en_i   (hi_en_i),
        .lo_en_i   (lo_en_i),
        .stat_en_i (stat_en_i),
        .window_i  (ctl.window),
        .data_oe_o (data_oe_o),
        .done_oe_o (done_oe_o),
        .ser_oe_o  (ser_oe_o)
    );

    assign trial_o   = code;
    assign data_o    = code;
    assign done_o    = ~ctl.run;
    assign clk_run_o = ctl.run;
    assign sync_o    = ctl.strobe;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
    parameter int N = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         full_mode_i,
    input logic [N-1:0] trial_o,
    input logic [N-1:0] data_o,
    input logic         done_o,
    input logic         ser_o,
    input logic         sync_o,
    input logic         ser_oe_o,
    input logic         clk_run_o
);
    localparam logic [N-1:0] TOP_ONLY = {1'b1, {(N-1){1'b0}}};

    // R1
    start_loads_top_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (trial_o == TOP_ONLY) && !done_o);

    // R2
    fall_begins_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(start_i) |=> clk_run_o && !done_o);

    // R5
    short_tail_bits_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(done_o) && !full_mode_i) |-> (data_o[1:0] == 2'b10));

    // R6
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(sync_o));

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(done_o) && !$past(start_i)) |-> $stable(data_o));

    // R9
    strobe_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        sync_o |-> ser_oe_o && clk_run_o);

    // R9
    serial_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) |=> $stable(ser_o));
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.N(N)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .full_mode_i (full_mode_i),
    .trial_o     (trial_o),
    .data_o      (data_o),
    .done_o      (done_o),
    .ser_o       (ser_o),
    .sync_o      (sync_o),
    .ser_oe_o    (ser_oe_o),
    .clk_run_o   (clk_run_o)
);

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
    localparam int N    = 10;
    localparam int STEP = 4;

    typedef struct {
        logic [N-1:0] val;
        int           nb;
        bit           full;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst;
    logic         start_i, full_mode_i, cmp_i;
    logic         hi_en_i, lo_en_i, stat_en_i;
    logic [N-1:0] trial_o, data_o, data_oe_o;
    logic         done_o, done_oe_o, ser_o, sync_o, ser_oe_o, clk_run_o;
    logic [N-1:0] ain;

    int   n_chk  = 0;
    int   n_fail = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    always_comb cmp_i = (trial_o > ain);

    sar_conv_ctrl u_sar_conv_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .full_mode_i(full_mode_i),
        .cmp_i(cmp_i), .hi_en_i(hi_en_i), .lo_en_i(lo_en_i), .stat_en_i(stat_en_i),
        .trial_o(trial_o), .data_o(data_o), .data_oe_o(data_oe_o),
        .done_o(done_o), .done_oe_o(done_oe_o), .ser_o(ser_o), .sync_o(sync_o),
        .ser_oe_o(ser_oe_o), .clk_run_o(clk_run_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] expect_code(input logic [N-1:0] a, input bit full);
        return full ? a : {a[N-1:2], 2'b10};
    endfunction

    // scoreboard monitor
    logic         prev_sync = 1'b0;
    logic         prev_done = 1'b1;
    logic [N-1:0] ser_word  = '0;
    int           ser_cnt   = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done_o && !prev_done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected completion", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(data_o == e.val, e.full ? "R4 result" : "R5 short result",
                          32'(data_o), 32'(e.val));
                    check(ser_cnt == e.nb, "R9 sync edge count", ser_cnt, e.nb);
                    if (e.full)
                        check(ser_word == e.val, "R9 serial word", 32'(ser_word), 32'(e.val));
                    else
                        check(ser_word[7:0] == e.val[N-1:2], "R9 short serial word",
                              32'(ser_word[7:0]), 32'(e.val[N-1:2]));
                end
            end
            if (sync_o && !prev_sync) begin
                ser_word = {ser_word[N-2:0], ser_o};
                ser_cnt++;
            end
            if (!ser_oe_o) begin
                ser_word = '0;
                ser_cnt  = 0;
            end
            prev_sync = sync_o;
            prev_done = done_o;
        end
    end

    // driver: start pulse, with optional expectation push
    task automatic launch(input logic [N-1:0] a, input bit full, input bit push);
        exp_t e;
        @(negedge clk);
        ain         = a;
        full_mode_i = full;
        start_i     = 1'b1;
        if (push) begin
            e.val  = expect_code(a, full);
            e.nb   = full ? N : 8;
            e.full = full;
            exp_q.push_back(e);
        end
        @(negedge clk);
        check(trial_o == 10'h200, "R1 trial top only", 32'(trial_o), 32'h200);
        check(!done_o && clk_run_o, "R1 busy while start", 32'({done_o, clk_run_o}), 32'b01);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic follow(input bit full);
        int total;
        total = full ? 12 * STEP : 10 * STEP;
        for (int n = 0; n <= total; n++) begin
            @(negedge clk);
            if (n == 2 * STEP - 1)
                check(trial_o[N-2] == 1'b0, "R3 bit8 before top decision", 32'(trial_o[N-2]), 0);
            if (n == 2 * STEP) begin
                check(trial_o[N-1] == ain[N-1], "R3 top decision", 32'(trial_o[N-1]), 32'(ain[N-1]));
                check(trial_o[N-2] == 1'b1, "R3 next trial on", 32'(trial_o[N-2]), 1);
            end
            if (n == STEP) begin
                check(clk_run_o == 1'b1, "R10 run during conversion", 32'(clk_run_o), 1);
                check(ser_oe_o == 1'b1, "R9 serial driven in conversion", 32'(ser_oe_o), 1);
            end
            if (n == total - 1)
                check(done_o == 1'b0, "R6 busy before final step", 32'(done_o), 0);
            if (n == total) begin
                check(done_o == 1'b1, "R6 complete on time", 32'(done_o), 1);
                check(clk_run_o == 1'b0, "R10 run stops", 32'(clk_run_o), 0);
                check(ser_oe_o == 1'b0, "R9 serial floats after", 32'(ser_oe_o), 0);
            end
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] held;
        rst = 1'b1; start_i = 1'b0; full_mode_i = 1'b1; ain = '0;
        hi_en_i = 1'b1; lo_en_i = 1'b1; stat_en_i = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done_o == 1'b1, "R6 reset done", 32'(done_o), 1);
        check(clk_run_o == 1'b0, "R10 reset idle", 32'(clk_run_o), 0);
        check(ser_oe_o == 1'b0, "R9 reset serial floats", 32'(ser_oe_o), 0);

        // R4 full-mode patterns
        launch(10'h000, 1'b1, 1'b1); follow(1'b1);
        launch(10'h3FF, 1'b1, 1'b1); follow(1'b1);
        launch(10'h200, 1'b1, 1'b1); follow(1'b1);
        launch(10'h1FF, 1'b1, 1'b1); follow(1'b1);
        launch(10'h2A5, 1'b1, 1'b1); follow(1'b1);

        // R5 short-mode patterns
        launch(10'h3FF, 1'b0, 1'b1); follow(1'b0);
        launch(10'h000, 1'b0, 1'b1); follow(1'b0);
        launch(10'h155, 1'b0, 1'b1); follow(1'b0);

        // R2 restart in mid conversion
        launch(10'h3C3, 1'b1, 1'b0);
        repeat (20) @(negedge clk);
        launch(10'h0F0, 1'b1, 1'b1); follow(1'b1);

        // R8 result held while comparator changes
        held = data_o;
        ain  = ~ain;
        repeat (30) @(negedge clk);
        check(data_o == held, "R8 result held", 32'(data_o), 32'(held));
        check(done_o == 1'b1, "R8 stays complete", 32'(done_o), 1);

        // R7 enables
        hi_en_i = 1'b0; lo_en_i = 1'b1; stat_en_i = 1'b0;
        @(negedge clk);
        check(data_oe_o == 10'h0FF, "R7 low only", 32'(data_oe_o), 32'h0FF);
        check(done_oe_o == 1'b0, "R7 status off", 32'(done_oe_o), 0);
        hi_en_i = 1'b1; lo_en_i = 1'b0; stat_en_i = 1'b1;
        @(negedge clk);
        check(data_oe_o == 10'h300, "R7 high only", 32'(data_oe_o), 32'h300);
        check(done_oe_o == 1'b1, "R7 status on", 32'(done_oe_o), 1);
        hi_en_i = 1'b0; lo_en_i = 1'b0;
        @(negedge clk);
        check(data_oe_o == 10'h000, "R7 all off", 32'(data_oe_o), 0);
        check(data_o == held, "R8 enables leave result", 32'(data_o), 32'(held));

        check(exp_q.size() == 0, "R6 all conversions completed", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule